// File: doc/BRIEF.md
# Lighting Universe Streaming Sequencer

This controller keeps a serial lighting transmitter supplied with one full universe of 512 channel bytes, then pauses for a programmable gap and starts over. It owns one Wishbone classic master port. Two slaves share that port and are told apart by address: a serial peripheral controller that talks to the upstream host, and the lighting transmitter.

Each universe opens with a header. The header is a host read command that starts at channel address zero, followed by a write that switches the transmitter on. After the header, the transmitter paces the transfer through a level-sensitive ready interrupt. Each time the interrupt is high while the controller is idle-waiting, one byte is read from the host controller and written to the transmitter's data register.

After the byte for the last channel has been forwarded, the bus stays quiet for a counted number of clock cycles, and then the header is sent again. A bus error response on any access abandons the universe and restarts it from the header.

Top module: `dmx_stream_sup`

## Requirements
- R1: While `rst` is sampled high, the strobes are low in the following cycle and the channel count is cleared. The first access after reset is released is the first header write.
- R2: `wb_cyc_o` and `wb_stb_o` rise and fall together. `wb_we_o`, `wb_adr_o` and `wb_dat_o` hold steady until `wb_ack_i` or `wb_err_i` is sampled high. The strobes are low in the next cycle, and two header accesses in a row are separated by exactly two idle cycles.
- R3: The header consists of three writes to address 0x0 carrying 0x03, 0x00 and 0x00 in that order. These are followed by a write of 0x01 to address 0x5, where bit 0 is the transmit enable.
- R4: After the header, and after every forwarded byte except the last one, no access is started until `dmx_rdy_irq_i` has been sampled high.
- R5: For each accepted ready request, the controller reads address 0x0 once and then writes the returned byte to address 0x4.
- R6: The channel count rises by one for each byte written to address 0x4. After the byte at count 511, the count returns to 0 and the controller enters the gap instead of waiting for the interrupt.
- R7: Let D be `ipd_cycles_i`. The bus is idle for exactly D+2 cycles between the acknowledge of the final channel write and the first header access, so D=0 gives 2 idle cycles. The interrupt is ignored during the gap.
- R8: `wb_err_i` ends the current access (the strobes are low in the next cycle), clears the channel count and restarts the header after two idle cycles. This takes priority over the end of a universe when it lands on the final channel write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_o | output | 1 | Bus cycle valid |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | 4 | Word address (0x0 host data, 0x1 host status, 0x4 transmitter data, 0x5 transmitter control) |
| wb_dat_o | output | 8 | Write data |
| wb_dat_i | input | 8 | Read data |
| wb_ack_i | input | 1 | Access acknowledge |
| wb_err_i | input | 1 | Access error |
| dmx_rdy_irq_i | input | 1 | Transmitter ready-for-channel request, level sensitive |
| ipd_cycles_i | input | 16 | Inter-universe gap length in clock cycles |

## Verification
Two events can land in the same clock edge: the end of a universe, when the byte for channel 511 is acknowledged, and the abort caused by an error response. The bench makes the transmitter model answer that final data write with `wb_err_i` instead of `wb_ack_i`. It uses a long programmed gap for that universe, so the two possible outcomes are easy to tell apart. The result is judged correct when the next access is the header write after two idle cycles, rather than after D+2, and when the universe that follows again streams all 512 channels starting from channel 0.

// File: rtl/dmx_sup_pkg.sv
package dmx_sup_pkg;

  typedef enum logic [1:0] {
    ST_INIT    = 2'd0,
    ST_DMXWAIT = 2'd1,
    ST_SPIREAD = 2'd2,
    ST_IPDWAIT = 2'd3
  } sup_state_e;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_BUSY = 2'd1,
    ENG_GAP  = 2'd2
  } eng_state_e;

  localparam int ADR_HOST_DATA = 'h0;
  localparam int ADR_HOST_STAT = 'h1;
  localparam int ADR_TX_DATA   = 'h4;
  localparam int ADR_TX_CTRL   = 'h5;
  localparam int HOST_RD_CMD   = 'h03;
  localparam int TX_ENABLE     = 'h01;
  localparam int HDR_STEPS     = 4;

  // header step -> byte sent on the bus
  function automatic int hdr_byte(input int step);
    case (step)
      0:       return HOST_RD_CMD;
      HDR_STEPS - 1: return TX_ENABLE;
      default: return 'h00;
    endcase
  endfunction

  // header step -> target address
  function automatic int hdr_addr(input int step);
    return (step == HDR_STEPS - 1) ? ADR_TX_CTRL : ADR_HOST_DATA;
  endfunction

  function automatic bit chan_is_last(input int cnt, input int total);
    return cnt == total - 1;
  endfunction

  function automatic int chan_next(input int cnt, input int total);
    return chan_is_last(cnt, total) ? 0 : cnt + 1;
  endfunction

endpackage

// File: rtl/dmx_sup_wb_engine.sv
module dmx_sup_wb_engine
  import dmx_sup_pkg::*;
#(
  parameter int ADR_W = 4,
  parameter int DAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             req_we_i,
  input  logic [ADR_W-1:0] req_adr_i,
  input  logic [DAT_W-1:0] req_dat_i,
  output logic             idle_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [DAT_W-1:0] rdata_o,
  output logic             wb_cyc_o,
  output logic             wb_stb_o,
  output logic             wb_we_o,
  output logic [ADR_W-1:0] wb_adr_o,
  output logic [DAT_W-1:0] wb_dat_o,
  input  logic [DAT_W-1:0] wb_dat_i,
  input  logic             wb_ack_i,
  input  logic             wb_err_i
);

  eng_state_e       st_q;
  logic             we_q;
  logic [ADR_W-1:0] adr_q;
  logic [DAT_W-1:0] dat_q;
  logic [DAT_W-1:0] rdata_q;
  logic             term;

  assign term = (st_q == ENG_BUSY) && (wb_ack_i || wb_err_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ENG_IDLE;
      we_q    <= 1'b0;
      adr_q   <= '0;
      dat_q   <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        ENG_IDLE: if (req_i) begin
          st_q  <= ENG_BUSY;
          we_q  <= req_we_i;
          adr_q <= req_adr_i;
          dat_q <= req_dat_i;
        end
        ENG_BUSY: if (term) begin
          st_q <= ENG_GAP;
          if (!we_q && !wb_err_i) rdata_q <= wb_dat_i;
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign idle_o   = (st_q == ENG_IDLE);
  assign done_o   = term;
  assign fault_o  = term && wb_err_i;
  assign rdata_o  = rdata_q;
  assign wb_cyc_o = (st_q == ENG_BUSY);
  assign wb_stb_o = (st_q == ENG_BUSY);
  assign wb_we_o  = we_q;
  assign wb_adr_o = adr_q;
  assign wb_dat_o = dat_q;

endmodule

// File: rtl/dmx_sup_chan_counter.sv
module dmx_sup_chan_counter
  import dmx_sup_pkg::*;
#(
  parameter int CH_COUNT = 512,
  parameter int CNT_W    = (CH_COUNT > 1) ? $clog2(CH_COUNT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)  cnt_q <= '0;
    else if (inc_i)    cnt_q <= CNT_W'(chan_next(int'(cnt_q), CH_COUNT));
  end

  assign cnt_o  = cnt_q;
  assign last_o = chan_is_last(int'(cnt_q), CH_COUNT);

endmodule

// File: rtl/dmx_sup_gap_timer.sv
module dmx_sup_gap_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [DLY_W-1:0] len_i,
  output logic             expired_o
);

  logic [DLY_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                 left_q <= '0;
    else if (load_i)         left_q <= len_i;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign expired_o = (left_q == '0);

endmodule

// File: rtl/dmx_stream_sup.sv
module dmx_stream_sup
  import dmx_sup_pkg::*;
#(
  parameter int ADR_W    = 4,
  parameter int DAT_W    = 8,
  parameter int DLY_W    = 16,
  parameter int CH_COUNT = 512,
  parameter int CNT_W    = (CH_COUNT > 1) ? $clog2(CH_COUNT) : 1,
  parameter int STEP_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic             wb_cyc_o,
  output logic             wb_stb_o,
  output logic             wb_we_o,
  output logic [ADR_W-1:0] wb_adr_o,
  output logic [DAT_W-1:0] wb_dat_o,
  input  logic [DAT_W-1:0] wb_dat_i,
  input  logic             wb_ack_i,
  input  logic             wb_err_i,
  input  logic             dmx_rdy_irq_i,
  input  logic [DLY_W-1:0] ipd_cycles_i
);

  sup_state_e        state_q;
  logic [STEP_W-1:0] step_q;

  logic             req, req_we;
  logic [ADR_W-1:0] req_adr;
  logic [DAT_W-1:0] req_dat;
  logic             eng_idle;
  logic [DAT_W-1:0] host_byte;
  logic [CNT_W-1:0] chan_cnt;
  logic             chan_last;

  // named internal events
  logic acc_done, acc_err, chan_fwd, univ_end, gap_expired;
  logic in_init, in_dmxwait, in_spiread, in_ipd;

  assign in_init    = (state_q == ST_INIT);
  assign in_dmxwait = (state_q == ST_DMXWAIT);
  assign in_spiread = (state_q == ST_SPIREAD);
  assign in_ipd     = (state_q == ST_IPDWAIT);

  assign chan_fwd = in_spiread && (step_q == STEP_W'(1)) && acc_done && !acc_err;
  assign univ_end = chan_fwd && chan_last;

  // request decode
  always_comb begin
    req     = (in_init || in_spiread) && eng_idle;
    req_we  = 1'b1;
    req_adr = ADR_W'(hdr_addr(int'(step_q)));
    req_dat = DAT_W'(hdr_byte(int'(step_q)));
    if (in_spiread) begin
      if (step_q == '0) begin
        req_we  = 1'b0;
        req_adr = ADR_W'(ADR_HOST_DATA);
        req_dat = '0;
      end else begin
        req_adr = ADR_W'(ADR_TX_DATA);
        req_dat = host_byte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_INIT;
      step_q  <= '0;
    end else if (acc_err) begin
      state_q <= ST_INIT;
      step_q  <= '0;
    end else begin
      case (state_q)
        ST_INIT: if (acc_done) begin
          if (step_q == STEP_W'(HDR_STEPS - 1)) begin
            state_q <= ST_DMXWAIT;
            step_q  <= '0;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        ST_DMXWAIT: if (dmx_rdy_irq_i) begin
          state_q <= ST_SPIREAD;
          step_q  <= '0;
        end
        ST_SPIREAD: if (acc_done) begin
          if (step_q == '0) begin
            step_q <= STEP_W'(1);
          end else begin
            step_q  <= '0;
            state_q <= chan_last ? ST_IPDWAIT : ST_DMXWAIT;
          end
        end
        default: if (gap_expired) state_q <= ST_INIT;
      endcase
    end
  end

  dmx_sup_wb_engine #(.ADR_W(ADR_W), .DAT_W(DAT_W)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req),
    .req_we_i (req_we),
    .req_adr_i(req_adr),
    .req_dat_i(req_dat),
    .idle_o   (eng_idle),
    .done_o   (acc_done),
    .fault_o  (acc_err),
    .rdata_o  (host_byte),
    .wb_cyc_o (wb_cyc_o),
    .wb_stb_o (wb_stb_o),
    .wb_we_o  (wb_we_o),
    .wb_adr_o (wb_adr_o),
    .wb_dat_o (wb_dat_o),
    .wb_dat_i (wb_dat_i),
    .wb_ack_i (wb_ack_i),
    .wb_err_i (wb_err_i)
  );

  dmx_sup_chan_counter #(.CH_COUNT(CH_COUNT), .CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr_i (acc_err),
    .inc_i (chan_fwd),
    .cnt_o (chan_cnt),
    .last_o(chan_last)
  );

  dmx_sup_gap_timer #(.DLY_W(DLY_W)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .load_i   (univ_end),
    .len_i    (ipd_cycles_i),
    .expired_o(gap_expired)
  );

endmodule

// File: rtl/dmx_sup_checker.sv
module dmx_sup_checker #(
  parameter int ADR_W = 4,
  parameter int DAT_W = 8,
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc,
  input logic             stb,
  input logic             we,
  input logic [ADR_W-1:0] adr,
  input logic [DAT_W-1:0] dat,
  input logic             ack,
  input logic             err,
  input logic             irq,
  input logic             in_init,
  input logic             in_dmxwait,
  input logic             in_spiread,
  input logic             in_ipd,
  input logic             chan_fwd,
  input logic             univ_end,
  input logic [CNT_W-1:0] chan_cnt
);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> !cyc && !stb && in_init && chan_cnt == '0);

  a_r2_hold_until_reply: assert property (@(posedge clk) disable iff (rst)
    cyc && !ack && !err |=> cyc && stb && $stable(adr) && $stable(we) && $stable(dat));

  a_r2_release_after_reply: assert property (@(posedge clk) disable iff (rst)
    cyc && (ack || err) |=> !cyc && !stb);

  a_r4_quiet_while_waiting: assert property (@(posedge clk) disable iff (rst)
    in_dmxwait |-> !cyc);

  a_r4_irq_gates_read: assert property (@(posedge clk) disable iff (rst)
    in_dmxwait && !irq |=> !in_spiread);

  a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
    chan_fwd && !univ_end |=> chan_cnt == $past(chan_cnt) + 1'b1);

  a_r6_wrap_to_gap: assert property (@(posedge clk) disable iff (rst)
    univ_end |=> in_ipd && chan_cnt == '0);

  a_r7_gap_quiet: assert property (@(posedge clk) disable iff (rst)
    in_ipd |-> !cyc);

  a_r8_error_restart: assert property (@(posedge clk) disable iff (rst)
    cyc && err |=> in_init && !cyc && chan_cnt == '0);

endmodule

bind dmx_stream_sup dmx_sup_checker #(.ADR_W(ADR_W), .DAT_W(DAT_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cyc       (wb_cyc_o),
  .stb       (wb_stb_o),
  .we        (wb_we_o),
  .adr       (wb_adr_o),
  .dat       (wb_dat_o),
  .ack       (wb_ack_i),
  .err       (wb_err_i),
  .irq       (dmx_rdy_irq_i),
  .in_init   (in_init),
  .in_dmxwait(in_dmxwait),
  .in_spiread(in_spiread),
  .in_ipd    (in_ipd),
  .chan_fwd  (chan_fwd),
  .univ_end  (univ_end),
  .chan_cnt  (chan_cnt)
);

// File: tb/test_dmx_stream_sup.sv
module test_dmx_stream_sup;

  localparam int CH    = 512;
  localparam int ERR_U = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc, stb, we;
  logic [3:0]  adr;
  logic [7:0]  dat_o;
  logic [7:0]  rdat = 8'h00;
  logic        ack = 1'b0, err = 1'b0, irq = 1'b0;
  logic [15:0] ipd = 16'd0;

  always #10 clk = ~clk;

  dmx_stream_sup i_dmx_stream_sup (
    .clk(clk), .rst(rst),
    .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_we_o(we), .wb_adr_o(adr), .wb_dat_o(dat_o),
    .wb_dat_i(rdat), .wb_ack_i(ack), .wb_err_i(err),
    .dmx_rdy_irq_i(irq), .ipd_cycles_i(ipd)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0, closed = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hb(input int u, input int ch);
    return 8'((ch * 37 + u * 11 + 5) & 255);
  endfunction

  function automatic int gap_for(input int u);
    case (u)
      0: return 0;
      1: return 37;
      2: return 50;
      3: return 5;
      default: return 0;
    endcase
  endfunction

  // scoreboard: {we, adr[3:0], dat[7:0]}
  logic [12:0] exp_q[$];
  logic [13:0] act_q[$];

  task automatic push_header();
    exp_q.push_back({1'b1, 4'h0, 8'h03});   // R3
    exp_q.push_back({1'b1, 4'h0, 8'h00});
    exp_q.push_back({1'b1, 4'h0, 8'h00});
    exp_q.push_back({1'b1, 4'h5, 8'h01});
  endtask

  task automatic push_universe(input int u);
    push_header();
    for (int ch = 0; ch < CH; ch++) begin
      exp_q.push_back({1'b0, 4'h0, 8'h00});  // R5 read
      exp_q.push_back({1'b1, 4'h4, hb(u, ch)});
    end
  endtask

  // slave models: host controller and transmitter
  int s_univ = -1, s_rd = 0, s_dmx = 0, s_wait = 0, n_acc = 0, irq_cnt = 0;
  always @(negedge clk) begin
    if (irq_cnt > 0) begin
      irq_cnt--;
      if (irq_cnt == 0) irq = 1'b1;
    end
    if (ack || err) begin
      ack = 1'b0;
      err = 1'b0;
    end else if (cyc) begin
      if (s_wait < n_acc % 3) s_wait++;
      else begin
        s_wait = 0;
        n_acc++;
        if (we && adr == 4'h0 && dat_o == 8'h03) begin
          s_univ++; s_rd = 0; s_dmx = 0;
        end
        if (!we && adr == 4'h0) begin
          rdat = hb(s_univ, s_rd);
          s_rd++;
        end
        if (we && adr == 4'h4 && s_univ == ERR_U && s_dmx == CH - 1) err = 1'b1;
        else ack = 1'b1;
        if (we && adr == 4'h4) s_dmx++;
        if (we && (adr == 4'h4 || adr == 4'h5)) begin
          irq = 1'b0;
          irq_cnt = (s_dmx % 4) + 1;
        end
        act_q.push_back({err, we, adr, dat_o});
      end
    end
  end

  // monitor
  int  m_univ = -1, m_dmx = 0, idle = 0, exp_gap = -1;
  bit  prev_cyc = 0, irq_seen = 0, after_fwd = 0;
  string gap_req = "R2";
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (irq) irq_seen = 1;
      if (cyc && !prev_cyc) begin
        chk(stb == 1'b1, "R2 stb with cyc", stb, 1);
        if (exp_gap >= 0) chk(idle == exp_gap, gap_req, idle, exp_gap);
        if (!we && adr == 4'h0 && after_fwd) chk(irq_seen, "R4 read before irq", 0, 1);
        idle = 0;
        exp_gap = -1;
        after_fwd = 0;
      end
      if (!cyc) idle++;
      prev_cyc = cyc;
      while (act_q.size() > 0) begin
        logic [13:0] a;
        logic [12:0] e;
        a = act_q.pop_front();
        if (exp_q.size() == 0) begin
          chk(0, "R3 unexpected access", int'(a[12:0]), 0);
        end else begin
          e = exp_q.pop_front();
          if (e[12] == 1'b0) chk(a[12:8] == e[12:8], "R5 read access", int'(a[12:8]), int'(e[12:8]));
          else               chk(a[12:0] == e, "R3/R5/R6 access", int'(a[12:0]), int'(e));
        end
        if (a[12] && a[11:8] == 4'h0 && a[7:0] == 8'h03) begin
          m_univ++; m_dmx = 0;
          ipd = 16'(gap_for(m_univ));
          if (m_univ == 4) done = 1;
        end
        if (a[13]) begin
          exp_gap = 2; gap_req = "R8 restart gap";
        end else if (a[12] && a[11:8] == 4'h4) begin
          m_dmx++;
          irq_seen = 0;
          if (m_dmx == CH) begin
            exp_gap = int'(ipd) + 2; gap_req = "R7 gap length";
          end else after_fwd = 1;
        end else if (a[12] && a[11:8] == 4'h5) begin
          irq_seen = 0; after_fwd = 1;
        end else if (a[12] && a[11:8] == 4'h0) begin
          exp_gap = 2; gap_req = "R2 idle between accesses";
        end
      end
    end
  end

  task automatic close_run();
    if (!closed) begin
      closed = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    push_universe(0);
    push_universe(1);
    push_universe(2);              // final write answered with err (R8)
    push_universe(3);
    exp_q.push_back({1'b1, 4'h0, 8'h03});
    repeat (3) @(negedge clk);
    chk(cyc == 1'b0 && stb == 1'b0, "R1 strobes in reset", {cyc, stb}, 0);
    @(negedge clk);
    chk(cyc == 1'b0, "R1 strobes in reset", cyc, 0);
    rst = 1'b0;
    wait (done);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all items seen", exp_q.size(), 0);
    close_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    close_run();
  end

endmodule